// File: doc/BRIEF.md
# SMT Thread Priority Register File

This block keeps one 3-bit hardware priority for each hardware thread of a simultaneous-multithreading core and turns those priorities into fetch-slot weights for the core's fetch arbiter. Software can change a priority in two ways. It can execute a priority-hint no-op, which names the same general register three times. It can also perform a direct write that carries a thread index, a requested level and the writer's privilege. Every request is checked against a per-level privilege table. A request the writer may not make is dropped, and a one-cycle violation flag is raised.

A thread's weight depends only on how far its priority sits above the lowest priority among the threads that are switched on. Level 0 switches a thread off completely: that thread gets weight zero and takes no part in the minimum. Both write paths can present a request in the same cycle. When both are granted for the same thread, the direct write takes precedence.

Top module: `thread_prio_regfile`

## Requirements
- R1: After reset every thread holds priority 4, `viol_o` is 0 and every weight is 1.
- R2: Privilege codes on `dir_priv_i`/`hint_priv_i` are 0 = user, 1 = supervisor, 2 = hypervisor and 3 = none. User may set levels 2 to 4, supervisor levels 1 to 6, hypervisor levels 0 to 7, and code 3 may set no level. A granted request becomes visible on `prio_o` after the clock edge that samples it.
- R3: A denied request leaves every stored priority unchanged. It drives `viol_o` high for exactly the one cycle that follows the edge that sampled it.
- R4: A hint whose three register numbers are equal maps to a level as follows: 7→7, 3→6, 5→5, 2→4, 6→3, 1→2, 31→1. The mapped level is then checked like a direct write.
- R5: A hint whose register numbers differ, or whose shared number is not in the R4 list, changes no priority and does not raise `viol_o`.
- R6: Thread i's weight is 2^(p_i − m), where m is the minimum priority over the threads whose priority is nonzero. Thread i occupies bits `[7i+6:7i]` of `weight_o`, and its priority occupies bits `[3i+2:3i]` of `prio_o`.
- R7: A thread at priority 0 has weight 0 and is left out of m. When every thread is at 0, every weight is 0.
- R8: When a direct write and a hint are both granted in one cycle for the same thread, the direct level is stored. When they target different threads, both are stored. A denied request on one path does not block a granted request on the other, and the denied request still raises `viol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_valid_i | input | 1 | Direct write request |
| dir_tid_i | input | 2 | Target thread of the direct write |
| dir_level_i | input | 3 | Requested level of the direct write |
| dir_priv_i | input | 2 | Writer privilege for the direct write |
| hint_valid_i | input | 1 | A no-op instruction is being retired |
| hint_tid_i | input | 2 | Thread that issued the no-op |
| hint_ra_i | input | 5 | First register number of the no-op |
| hint_rb_i | input | 5 | Second register number of the no-op |
| hint_rc_i | input | 5 | Third register number of the no-op |
| hint_priv_i | input | 2 | Privilege of the issuing thread |
| prio_o | output | 12 | Stored priorities, 3 bits per thread |
| weight_o | output | 28 | Fetch-slot weights, 7 bits per thread |
| viol_o | output | 1 | One-cycle flag for a denied request |

## Verification
A direct write and a priority hint can land in the same cycle. Each of them can be granted or denied, and they can target the same thread or different threads. The bench drives both paths in one cycle in four combinations: same thread with both granted, different threads, a denied direct write with a granted hint, and a granted direct write with a denied hint. On the following cycle it compares every priority, every weight and the violation flag against its own model of R8. A property in the checker also requires the direct level to be stored whenever both paths are granted for one thread.

// File: rtl/thread_prio_pkg.sv
package thread_prio_pkg;
  localparam int PRIO_W   = 3;
  localparam int REG_W    = 5;
  localparam int NUM_LVL  = 1 << PRIO_W;
  localparam int WEIGHT_W = NUM_LVL - 1;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_NONE = 2'd3
  } priv_e;

  localparam logic [PRIO_W-1:0] USER_LO = 3'd2;
  localparam logic [PRIO_W-1:0] USER_HI = 3'd4;
  localparam logic [PRIO_W-1:0] SUP_LO  = 3'd1;
  localparam logic [PRIO_W-1:0] SUP_HI  = 3'd6;

  // register number that selects level e (index = level)
  localparam logic [NUM_LVL-1:1][REG_W-1:0] HINT_REG =
    {5'd7, 5'd3, 5'd5, 5'd2, 5'd6, 5'd1, 5'd31};

  function automatic logic level_allowed(logic [1:0] priv, logic [PRIO_W-1:0] lvl);
    unique case (priv_e'(priv))
      PRIV_USER: return (lvl >= USER_LO) && (lvl <= USER_HI);
      PRIV_SUP:  return (lvl >= SUP_LO) && (lvl <= SUP_HI);
      PRIV_HYP:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/prio_hint_decode.sv
module prio_hint_decode
  import thread_prio_pkg::*;
(
  input  logic [REG_W-1:0]  ra_i,
  input  logic [REG_W-1:0]  rb_i,
  input  logic [REG_W-1:0]  rc_i,
  output logic              match_o,
  output logic [PRIO_W-1:0] level_o
);
  logic              same;
  logic [NUM_LVL-1:1] hit;

  assign same = (ra_i == rb_i) && (rb_i == rc_i);

  for (genvar e = 1; e < NUM_LVL; e++) begin : g_ent
    assign hit[e] = same && (ra_i == HINT_REG[e]);
  end

  always_comb begin
    level_o = '0;
    for (int e = 1; e < NUM_LVL; e++) begin
      if (hit[e]) level_o = PRIO_W'(e);
    end
  end

  assign match_o = |hit;
endmodule

// File: rtl/prio_priv_gate.sv
module prio_priv_gate
  import thread_prio_pkg::*;
(
  input  logic              req_i,
  input  logic [1:0]        priv_i,
  input  logic [PRIO_W-1:0] level_i,
  output logic              grant_o,
  output logic              deny_o
);
  logic ok;
  assign ok      = level_allowed(priv_i, level_i);
  assign grant_o = req_i && ok;
  assign deny_o  = req_i && !ok;
endmodule

// File: rtl/prio_weight_calc.sv
module prio_weight_calc
  import thread_prio_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0][PRIO_W-1:0]   prio_i,
  output logic [NUM_THREADS-1:0][WEIGHT_W-1:0] weight_o
);
  logic [PRIO_W-1:0] min_act;

  // minimum over threads that are switched on
  always_comb begin
    min_act = '1;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (prio_i[t] != '0 && prio_i[t] < min_act) min_act = prio_i[t];
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_w
    logic [PRIO_W-1:0] shamt;
    assign shamt       = prio_i[t] - min_act;
    assign weight_o[t] = (prio_i[t] == '0) ? '0 : (WEIGHT_W'(1) << shamt);
  end
endmodule

// File: rtl/thread_prio_regfile.sv
module thread_prio_regfile
  import thread_prio_pkg::*;
#(
  parameter int                NUM_THREADS = 4,
  parameter int                TID_W       = $clog2(NUM_THREADS),
  parameter logic [PRIO_W-1:0] RESET_LVL   = 3'd4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            dir_valid_i,
  input  logic [TID_W-1:0]                dir_tid_i,
  input  logic [PRIO_W-1:0]               dir_level_i,
  input  logic [1:0]                      dir_priv_i,
  input  logic                            hint_valid_i,
  input  logic [TID_W-1:0]                hint_tid_i,
  input  logic [REG_W-1:0]                hint_ra_i,
  input  logic [REG_W-1:0]                hint_rb_i,
  input  logic [REG_W-1:0]                hint_rc_i,
  input  logic [1:0]                      hint_priv_i,
  output logic [NUM_THREADS*PRIO_W-1:0]   prio_o,
  output logic [NUM_THREADS*WEIGHT_W-1:0] weight_o,
  output logic                            viol_o
);
  logic              hint_hit;
  logic [PRIO_W-1:0] hint_lvl;
  logic              dir_grant, dir_deny, hint_grant, hint_deny;
  logic              viol_q;
  logic [NUM_THREADS-1:0][PRIO_W-1:0]   prio_q;
  logic [NUM_THREADS-1:0][WEIGHT_W-1:0] weight;

  prio_hint_decode u_hint (
    .ra_i    (hint_ra_i),
    .rb_i    (hint_rb_i),
    .rc_i    (hint_rc_i),
    .match_o (hint_hit),
    .level_o (hint_lvl)
  );

  prio_priv_gate u_dir_gate (
    .req_i   (dir_valid_i),
    .priv_i  (dir_priv_i),
    .level_i (dir_level_i),
    .grant_o (dir_grant),
    .deny_o  (dir_deny)
  );

  // unmatched triple is a plain no-op: never a request
  prio_priv_gate u_hint_gate (
    .req_i   (hint_valid_i && hint_hit),
    .priv_i  (hint_priv_i),
    .level_i (hint_lvl),
    .grant_o (hint_grant),
    .deny_o  (hint_deny)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic dir_sel, hint_sel;
    assign dir_sel  = dir_grant && (dir_tid_i == TID_W'(t));
    assign hint_sel = hint_grant && (hint_tid_i == TID_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       prio_q[t] <= RESET_LVL;
      else if (dir_sel)  prio_q[t] <= dir_level_i;
      else if (hint_sel) prio_q[t] <= hint_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= dir_deny || hint_deny;
  end

  prio_weight_calc #(.NUM_THREADS(NUM_THREADS)) u_weight (
    .prio_i   (prio_q),
    .weight_o (weight)
  );

  assign prio_o   = prio_q;
  assign weight_o = weight;
  assign viol_o   = viol_q;
endmodule

// File: rtl/thread_prio_checker.sv
module thread_prio_checker
  import thread_prio_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            dir_valid_i,
  input logic [TID_W-1:0]                dir_tid_i,
  input logic [PRIO_W-1:0]               dir_level_i,
  input logic [1:0]                      dir_priv_i,
  input logic                            hint_valid_i,
  input logic [TID_W-1:0]                hint_tid_i,
  input logic [REG_W-1:0]                hint_ra_i,
  input logic [REG_W-1:0]                hint_rb_i,
  input logic [REG_W-1:0]                hint_rc_i,
  input logic [1:0]                      hint_priv_i,
  input logic [NUM_THREADS*PRIO_W-1:0]   prio_o,
  input logic [NUM_THREADS*WEIGHT_W-1:0] weight_o,
  input logic                            viol_o
);
  logic hint_same;
  logic any_on, any_one;
  logic dir_bad, dir_good;

  assign hint_same = (hint_ra_i == hint_rb_i) && (hint_rb_i == hint_rc_i);
  assign dir_bad   = dir_valid_i && !level_allowed(dir_priv_i, dir_level_i);
  assign dir_good  = dir_valid_i && level_allowed(dir_priv_i, dir_level_i);

  always_comb begin
    any_on  = 1'b0;
    any_one = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (prio_o[t*PRIO_W +: PRIO_W] != '0) any_on = 1'b1;
      if (weight_o[t*WEIGHT_W +: WEIGHT_W] == WEIGHT_W'(1)) any_one = 1'b1;
    end
  end

  // R3: a denied direct write alone changes no priority and flags
  a_r3_denied_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_bad && !hint_valid_i) |=> ($stable(prio_o) && viol_o));

  // R3: flag only ever follows a request
  a_r3_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(dir_valid_i || hint_valid_i));

  // R5: differing hint registers are a plain no-op
  a_r5_unmatched_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hint_valid_i && !hint_same && !dir_valid_i) |=> ($stable(prio_o) && !viol_o));

  // R6: lowest active thread always has weight 1
  a_r6_min_weight_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_on |-> any_one);

  // R8: direct write wins over a hint on the same thread
  a_r8_direct_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_good && hint_valid_i && hint_tid_i == dir_tid_i) |=>
    (prio_o[$past(dir_tid_i)*PRIO_W +: PRIO_W] == $past(dir_level_i)));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R7: thread switched off gets no fetch slots
    a_r7_off_no_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prio_o[t*PRIO_W +: PRIO_W] == '0) |-> (weight_o[t*WEIGHT_W +: WEIGHT_W] == '0));
    // R6: active thread always holds exactly one weight bit
    a_r6_weight_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prio_o[t*PRIO_W +: PRIO_W] != '0) |->
      ($countones(weight_o[t*WEIGHT_W +: WEIGHT_W]) == 1));
  end
endmodule

bind thread_prio_regfile thread_prio_checker #(
  .NUM_THREADS (NUM_THREADS),
  .TID_W       (TID_W)
) i_thread_prio_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dir_valid_i  (dir_valid_i),
  .dir_tid_i    (dir_tid_i),
  .dir_level_i  (dir_level_i),
  .dir_priv_i   (dir_priv_i),
  .hint_valid_i (hint_valid_i),
  .hint_tid_i   (hint_tid_i),
  .hint_ra_i    (hint_ra_i),
  .hint_rb_i    (hint_rb_i),
  .hint_rc_i    (hint_rc_i),
  .hint_priv_i  (hint_priv_i),
  .prio_o       (prio_o),
  .weight_o     (weight_o),
  .viol_o       (viol_o)
);

// File: tb/test_thread_prio_regfile.sv
module test_thread_prio_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int PW = 3;
  localparam int WW = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic       dir_valid = 1'b0;
  logic [1:0] dir_tid = '0;
  logic [2:0] dir_level = '0;
  logic [1:0] dir_priv = '0;
  logic       hint_valid = 1'b0;
  logic [1:0] hint_tid = '0;
  logic [4:0] hint_ra = '0, hint_rb = '0, hint_rc = '0;
  logic [1:0] hint_priv = '0;
  logic [NT*PW-1:0] prio;
  logic [NT*WW-1:0] weight;
  logic viol;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int model [NT];
  bit exp_viol;

  // {priv[7:6], tid[5:4], level[3:1], granted[0]}
  localparam logic [7:0] VEC [12] = '{
    8'b00_00_010_1, 8'b00_01_101_0, 8'b00_10_001_0, 8'b01_01_110_1,
    8'b01_10_000_0, 8'b01_11_111_0, 8'b10_11_111_1, 8'b10_10_000_1,
    8'b00_00_100_1, 8'b11_00_100_0, 8'b01_00_001_1, 8'b00_01_011_1
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_prio_regfile i_thread_prio_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .dir_valid_i(dir_valid), .dir_tid_i(dir_tid), .dir_level_i(dir_level), .dir_priv_i(dir_priv),
    .hint_valid_i(hint_valid), .hint_tid_i(hint_tid),
    .hint_ra_i(hint_ra), .hint_rb_i(hint_rb), .hint_rc_i(hint_rc), .hint_priv_i(hint_priv),
    .prio_o(prio), .weight_o(weight), .viol_o(viol)
  );

  function automatic bit permitted(int pv, int lv);
    case (pv)
      0: return lv >= 2 && lv <= 4;
      1: return lv >= 1 && lv <= 6;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int hint_map(int a, int b, int c);
    if (a != b || b != c) return 0;
    case (a)
      7: return 7; 3: return 6; 5: return 5; 2: return 4;
      6: return 3; 1: return 2; 31: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_weight(int t);
    int m = 8;
    for (int k = 0; k < NT; k++) if (model[k] != 0 && model[k] < m) m = model[k];
    if (model[t] == 0) return 0;
    return 1 << (model[t] - m);
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int t = 0; t < NT; t++) begin
      check(req, int'(prio[t*PW +: PW]), model[t], $sformatf("prio[%0d]", t));
      check(req, int'(weight[t*WW +: WW]), exp_weight(t), $sformatf("weight[%0d]", t));
    end
    check(req, int'(viol), int'(exp_viol), "viol");
  endtask

  // drive one cycle of requests, update model, return to idle after the edge
  task automatic step(input bit dv, input int dt, input int dl, input int dp,
                      input bit hv, input int ht, input int ra, input int rb, input int rc,
                      input int hp);
    int hl;
    bit dg, hg;
    hl = hint_map(ra, rb, rc);
    dg = dv && permitted(dp, dl);
    hg = hv && hl != 0 && permitted(hp, hl);
    exp_viol = (dv && !dg) || (hv && hl != 0 && !hg);
    if (hg) model[ht] = hl;
    if (dg) model[dt] = dl;
    dir_valid = dv; dir_tid = 2'(dt); dir_level = 3'(dl); dir_priv = 2'(dp);
    hint_valid = hv; hint_tid = 2'(ht); hint_ra = 5'(ra); hint_rb = 5'(rb); hint_rc = 5'(rc);
    hint_priv = 2'(hp);
    @(negedge clk);
    dir_valid = 1'b0; hint_valid = 1'b0;
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    exp_viol = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) model[t] = 4;
    exp_viol = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 R3 R6 R7: privilege table walk
    for (int i = 0; i < 12; i++) begin
      step(1'b1, int'(VEC[i][5:4]), int'(VEC[i][3:1]), int'(VEC[i][7:6]),
           1'b0, 0, 0, 0, 0, 0);
      check("R2", int'(viol), int'(!VEC[i][0]), $sformatf("vec %0d grant", i));
      check_all(VEC[i][0] ? "R2" : "R3");
    end
    idle_check("R3");

    // R4: hint encodings at hypervisor privilege
    for (int e = 1; e < 8; e++) begin
      int r;
      case (e)
        1: r = 31; 2: r = 1; 3: r = 6; 4: r = 2; 5: r = 5; 6: r = 3; default: r = 7;
      endcase
      step(1'b0, 0, 0, 0, 1'b1, e % NT, r, r, r, 2);
      check("R4", int'(prio[(e % NT)*PW +: PW]), e, $sformatf("hint reg %0d", r));
      check_all("R4");
    end
    // R4 R3: user hint to level 1 denied
    step(1'b0, 0, 0, 0, 1'b1, 2, 31, 31, 31, 0);
    check_all("R3");
    idle_check("R3");

    // R5: unmatched triples
    step(1'b0, 0, 0, 0, 1'b1, 1, 4, 4, 4, 2);
    check_all("R5");
    step(1'b0, 0, 0, 0, 1'b1, 1, 1, 1, 2, 0);
    check_all("R5");
    step(1'b0, 0, 0, 0, 1'b1, 1, 31, 31, 0, 3);
    check_all("R5");

    // R6: spread of weights
    step(1'b1, 0, 1, 2, 1'b0, 0, 0, 0, 0, 0);
    step(1'b1, 1, 7, 2, 1'b0, 0, 0, 0, 0, 0);
    step(1'b1, 2, 3, 2, 1'b0, 0, 0, 0, 0, 0);
    step(1'b1, 3, 5, 2, 1'b0, 0, 0, 0, 0, 0);
    check_all("R6");
    check("R6", int'(weight[1*WW +: WW]), 64, "max spread");

    // R7: switch off threads one by one
    for (int t = 0; t < NT; t++) begin
      step(1'b1, t, 0, 2, 1'b0, 0, 0, 0, 0, 0);
      check_all("R7");
    end
    check("R7", int'(weight), 0, "all off");

    // R8: both paths in one cycle
    step(1'b1, 0, 5, 2, 1'b1, 0, 7, 7, 7, 2);
    check_all("R8");
    check("R8", int'(prio[0 +: PW]), 5, "direct wins");
    step(1'b1, 1, 2, 0, 1'b1, 2, 3, 3, 3, 1);
    check_all("R8");
    step(1'b1, 3, 7, 1, 1'b1, 3, 2, 2, 2, 0);
    check_all("R8");
    check("R8", int'(prio[3*PW +: PW]), 4, "hint after denied direct");
    step(1'b1, 1, 6, 1, 1'b1, 2, 31, 31, 31, 0);
    check_all("R8");
    idle_check("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule